// File: doc/BRIEF.md
# Keypad Scan Code Capture

This block turns a 20-key matrix, shared with a six-digit multiplexed display, into 5-bit key codes for a host. A step counter walks through the display digit positions; the first five steps double as keypad row drives. On each step the four column return lines are sampled and reduced to a 2-bit column number. A full pass over all steps is one sweep. When the same key has been seen in a set number of consecutive sweeps, its code (step number above column number) is stored in a key code register and an interrupt request is raised.

The host side follows valid/ready rules. The interrupt request is the valid flag and a read-function strobe is the ready. While the strobe is high the stored code appears on the host read lines, and the request drops one clock later. Back-pressure: while a request is outstanding, no new key is taken and the stored code does not change. A key that stays debounced is taken at the first sweep end after the host has read or cleared the pending one. A separate clear input drops the request without reading it.

Top module: `key_scan_capture`

## Requirements
- R1: After reset the scan step is 0. It advances by one every STEP_CYCLES (default 4) clocks and wraps from STEPS-1 (default 5) back to 0.
- R2: A key on step s (0 to 4) and column c (0 to 3) produces the code {s[2:0], c[1:0]}. If several columns are active on one step, the lowest column is used. If keys on different steps are held, the lowest step in the sweep is used.
- R3: Column inputs seen during steps at or above KEY_ROWS (default 5) never produce a capture.
- R4: A key is captured only after it has been seen with the same code in DEB_SCANS (default 4) consecutive sweeps. A press covering fewer sweeps yields no capture.
- R5: A capture loads the code register and raises key_irq_o on the same clock edge.
- R6: A held key is captured once. A new capture needs DEB_SCANS consecutive sweeps with no key first.
- R7: While fn_rd_i is 1, host_rd_data_o shows the stored code; otherwise it is 0. A read while the request is raised drops key_irq_o on the next clock.
- R8: irq_clr_i drops key_irq_o on the next clock and leaves the stored code unchanged.
- R9: While key_irq_o is 1, no capture happens and the stored code holds. A key still debounced after the request drops is captured at a later sweep end.
- R10: Under reset key_irq_o is 0, the stored code is 0 and host_rd_data_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| col_i | input | 4 | Column return lines, active high, sampled per step |
| fn_rd_i | input | 1 | Read-function strobe (ready) |
| irq_clr_i | input | 1 | Drops the interrupt request |
| scan_step_o | output | 3 | Current scan step, shared with the display |
| key_irq_o | output | 1 | Interrupt request (valid) |
| host_rd_data_o | output | 5 | Stored key code while reading, else 0 |

## Verification
The embedded properties check these rules on every cycle: the step counter's advance and wrap, that captures fall only on sweep ends and only while no request is pending, that a captured code never names a step at or above KEY_ROWS, and that the code holds while a request waits. Other behaviours need whole scenarios from the bench, because they span many sweeps. These include the debounce length, the lowest-column and lowest-step choice, the single capture of a held key with rearm after release, and a key that waits behind a pending request and is taken after the read.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  typedef enum logic {ARM_READY = 1'b0, ARM_SPENT = 1'b1} arm_e;
endpackage

// File: rtl/scan_stepper.sv
module scan_stepper #(
  parameter int STEPS       = 6,
  parameter int STEP_CYCLES = 4,
  localparam int STEPW      = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [STEPW-1:0] step_o,
  output logic             tick_o,
  output logic             sweep_end_o
);
  localparam logic [STEPW-1:0] LAST_STEP = STEPW'(STEPS - 1);

  generate
    if (STEP_CYCLES > 1) begin : g_div
      localparam int SUBW = $clog2(STEP_CYCLES);
      logic [SUBW-1:0] sub_q;
      always_ff @(posedge clk) begin
        if (!rst_n)      sub_q <= '0;
        else if (tick_o) sub_q <= '0;
        else             sub_q <= sub_q + 1'b1;
      end
      assign tick_o = (sub_q == SUBW'(STEP_CYCLES - 1));
    end else begin : g_nodiv
      assign tick_o = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) step_o <= '0;
    else if (tick_o) step_o <= (step_o == LAST_STEP) ? '0 : step_o + 1'b1;
  end

  assign sweep_end_o = tick_o && (step_o == LAST_STEP);

  // R1: step stays in range and moves only on a tick
  a_r1_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_o <= LAST_STEP);
  a_r1_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && step_o == LAST_STEP) |=> step_o == '0);
  a_r1_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(step_o));
endmodule

// File: rtl/col_prio_enc.sv
module col_prio_enc #(
  parameter int COLS  = 4,
  localparam int COLW = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic [COLS-1:0] col_i,
  output logic            hit_o,
  output logic [COLW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (col_i[c]) idx_o = COLW'(c);
    end
  end
  assign hit_o = |col_i;
endmodule

// File: rtl/sweep_debounce.sv
module sweep_debounce
  import kscan_pkg::*;
#(
  parameter int STEPS     = 6,
  parameter int KEY_ROWS  = 5,
  parameter int COLS      = 4,
  parameter int DEB_SCANS = 4,
  localparam int STEPW    = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int COLW     = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODEW    = STEPW + COLW,
  localparam int CNTW     = $clog2(DEB_SCANS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             sweep_end_i,
  input  logic [STEPW-1:0] step_i,
  input  logic             hit_i,
  input  logic [COLW-1:0]  idx_i,
  input  logic             busy_i,
  output logic             cap_o,
  output logic [CODEW-1:0] cap_code_o
);
  localparam logic [CNTW-1:0] CNT_MAX = CNTW'(DEB_SCANS);

  logic             found_q, prev_hit_q;
  logic [CODEW-1:0] code_q, prev_code_q;
  logic [CNTW-1:0]  cnt_q, rel_q, cnt_next, rel_next;
  arm_e             arm_q;
  logic             hit_now, cur_found;
  logic [CODEW-1:0] cur_code;

  assign hit_now   = tick_i && (32'(step_i) < KEY_ROWS) && hit_i;
  assign cur_found = found_q || hit_now;
  assign cur_code  = found_q ? code_q : {step_i, idx_i};

  always_comb begin
    if (!cur_found)
      cnt_next = '0;
    else if (prev_hit_q && cur_code == prev_code_q)
      cnt_next = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_next = CNTW'(1);
    if (cur_found)
      rel_next = '0;
    else
      rel_next = (rel_q == CNT_MAX) ? rel_q : rel_q + 1'b1;
  end

  assign cap_o = sweep_end_i && cur_found && (arm_q == ARM_READY)
                 && !busy_i && (cnt_next >= CNT_MAX);
  assign cap_code_o = cur_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found_q <= 1'b0;
      code_q  <= '0;
    end else if (sweep_end_i) begin
      found_q <= 1'b0;
    end else if (hit_now && !found_q) begin
      found_q <= 1'b1;
      code_q  <= cur_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '0;
      rel_q       <= '0;
      prev_hit_q  <= 1'b0;
      prev_code_q <= '0;
      arm_q       <= ARM_READY;
    end else if (sweep_end_i) begin
      cnt_q       <= cnt_next;
      rel_q       <= rel_next;
      prev_hit_q  <= cur_found;
      prev_code_q <= cur_code;
      if (cap_o)                  arm_q <= ARM_SPENT;
      else if (rel_next >= CNT_MAX) arm_q <= ARM_READY;
    end
  end

  // R4: captures fall only on sweep ends
  a_r4_cap_on_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> sweep_end_i);
  // R9: no capture while a request is pending
  a_r9_no_cap_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !cap_o);
  // R3: a captured code never names a non-key step
  a_r3_row_range: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |-> 32'(cap_code_o[CODEW-1:COLW]) < KEY_ROWS);
  // R6: a capture disarms until release
  a_r6_single: assert property (@(posedge clk) disable iff (!rst_n)
    cap_o |=> arm_q == ARM_SPENT);
endmodule

// File: rtl/keycode_reg.sv
module keycode_reg #(
  parameter int CODEW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [CODEW-1:0] code_i,
  input  logic             fn_rd_i,
  input  logic             irq_clr_i,
  output logic             irq_o,
  output logic [CODEW-1:0] rd_data_o
);
  logic [CODEW-1:0] code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      irq_o  <= 1'b0;
    end else if (cap_i) begin
      code_q <= code_i;
      irq_o  <= 1'b1;
    end else if (fn_rd_i || irq_clr_i) begin
      irq_o  <= 1'b0;
    end
  end

  assign rd_data_o = fn_rd_i ? code_q : '0;

  // R5: capture loads code and raises request together
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> irq_o && code_q == $past(code_i));
  // R7: read of a pending request drops it
  a_r7_read_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_rd_i && irq_o) |=> !irq_o);
  // R8: clear drops the request
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr_i && !cap_i) |=> !irq_o);
  // R9: stored code holds while waiting
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> $stable(code_q));
endmodule

// File: rtl/key_scan_capture.sv
module key_scan_capture #(
  parameter int STEPS       = 6,
  parameter int STEP_CYCLES = 4,
  parameter int KEY_ROWS    = 5,
  parameter int COLS        = 4,
  parameter int DEB_SCANS   = 4,
  localparam int STEPW      = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int COLW       = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int CODEW      = STEPW + COLW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COLS-1:0]  col_i,
  input  logic             fn_rd_i,
  input  logic             irq_clr_i,
  output logic [STEPW-1:0] scan_step_o,
  output logic             key_irq_o,
  output logic [CODEW-1:0] host_rd_data_o
);
  logic             tick, sweep_end, hit, cap;
  logic [COLW-1:0]  idx;
  logic [CODEW-1:0] cap_code;

  scan_stepper #(.STEPS(STEPS), .STEP_CYCLES(STEP_CYCLES)) u_step (
    .clk(clk), .rst_n(rst_n), .step_o(scan_step_o),
    .tick_o(tick), .sweep_end_o(sweep_end));

  col_prio_enc #(.COLS(COLS)) u_enc (
    .col_i(col_i), .hit_o(hit), .idx_o(idx));

  sweep_debounce #(.STEPS(STEPS), .KEY_ROWS(KEY_ROWS), .COLS(COLS),
                   .DEB_SCANS(DEB_SCANS)) u_deb (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sweep_end_i(sweep_end),
    .step_i(scan_step_o), .hit_i(hit), .idx_i(idx), .busy_i(key_irq_o),
    .cap_o(cap), .cap_code_o(cap_code));

  keycode_reg #(.CODEW(CODEW)) u_reg (
    .clk(clk), .rst_n(rst_n), .cap_i(cap), .code_i(cap_code),
    .fn_rd_i(fn_rd_i), .irq_clr_i(irq_clr_i),
    .irq_o(key_irq_o), .rd_data_o(host_rd_data_o));

  // R10: reset leaves no request
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !key_irq_o);
endmodule

// File: tb/sim_key_scan_capture.sv
module sim_key_scan_capture;
  localparam int SWEEP = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] col_i;
  logic       fn_rd_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic [2:0] scan_step_o;
  logic       key_irq_o;
  logic [4:0] host_rd_data_o;

  logic [19:0] keys = '0;
  bit          ghost = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  key_scan_capture u0 (.clk(clk), .rst_n(rst_n), .col_i(col_i),
    .fn_rd_i(fn_rd_i), .irq_clr_i(irq_clr_i), .scan_step_o(scan_step_o),
    .key_irq_o(key_irq_o), .host_rd_data_o(host_rd_data_o));

  // key matrix model: key index = row*4 + column, row = scan step
  always_comb begin
    col_i = '0;
    if (ghost && scan_step_o == 3'd5) col_i = 4'b0110;
    for (int c = 0; c < 4; c++) begin
      int k;
      k = int'(scan_step_o) * 4 + c;
      if (k < 20 && keys[k]) col_i[c] = 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_irq(input int max, output bit got);
    got = 1'b0;
    for (int i = 0; i < max && !got; i++) begin
      cyc(1);
      if (key_irq_o) got = 1'b1;
    end
  endtask

  task automatic do_read(input string req, input int exp);
    fn_rd_i = 1'b1;
    #1;
    check(req, host_rd_data_o, exp);
    cyc(1);
    fn_rd_i = 1'b0;
    #1;
    check("R7 irq drop", key_irq_o, 0);
    check("R7 idle data", host_rd_data_o, 0);
  endtask

  task automatic release_all();
    keys = '0;
    ghost = 1'b0;
    cyc(6 * SWEEP);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cyc(3);
    check("R10 irq", key_irq_o, 0);
    check("R10 data", host_rd_data_o, 0);
    check("R1 step", scan_step_o, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_stepper();
    int bad = 0;
    for (int k = 1; k <= 60; k++) begin
      cyc(1);
      if (int'(scan_step_o) != (k / 4) % 6) bad++;
    end
    check("R1 step sequence mismatches", bad, 0);
  endtask

  task automatic t_single_key();
    bit got;
    keys[2 * 4 + 3] = 1'b1;
    cyc(3 * SWEEP - 1);
    check("R4 no early capture", key_irq_o, 0);
    wait_irq(4 * SWEEP, got);
    check("R5 capture raises irq", got, 1);
    do_read("R2 code row2 col3", 11);
    release_all();
  endtask

  task automatic t_short_press();
    keys[0] = 1'b1;
    cyc(2 * SWEEP);
    keys = '0;
    cyc(6 * SWEEP);
    check("R4 short press ignored", key_irq_o, 0);
  endtask

  task automatic t_multi();
    bit got;
    keys[1 * 4 + 3] = 1'b1;
    keys[1 * 4 + 1] = 1'b1;
    keys[3 * 4 + 0] = 1'b1;
    wait_irq(8 * SWEEP, got);
    check("R2 multi capture", got, 1);
    do_read("R2 lowest step and column", 5);
    release_all();
  endtask

  task automatic t_ghost();
    ghost = 1'b1;
    cyc(8 * SWEEP);
    check("R3 step5 columns ignored", key_irq_o, 0);
    release_all();
  endtask

  task automatic t_hold_one();
    bit got;
    keys[4 * 4 + 0] = 1'b1;
    wait_irq(8 * SWEEP, got);
    check("R6 first capture", got, 1);
    do_read("R6 code row4 col0", 16);
    cyc(8 * SWEEP);
    check("R6 held key no repeat", key_irq_o, 0);
    release_all();
    check("R6 release no capture", key_irq_o, 0);
    keys[4 * 4 + 0] = 1'b1;
    wait_irq(8 * SWEEP, got);
    check("R6 rearmed capture", got, 1);
    do_read("R6 rearmed code", 16);
    release_all();
  endtask

  task automatic t_backpressure();
    bit got;
    keys[3 * 4 + 2] = 1'b1;
    wait_irq(8 * SWEEP, got);
    check("R9 first capture", got, 1);
    release_all();
    keys[0 * 4 + 1] = 1'b1;
    cyc(6 * SWEEP);
    check("R9 request still pending", key_irq_o, 1);
    do_read("R9 old code kept", 14);
    wait_irq(2 * SWEEP, got);
    check("R9 waiting key taken", got, 1);
    do_read("R9 waiting code", 1);
    release_all();
  endtask

  task automatic t_clear();
    bit got;
    keys[2 * 4 + 2] = 1'b1;
    wait_irq(8 * SWEEP, got);
    check("R8 capture", got, 1);
    irq_clr_i = 1'b1;
    cyc(1);
    irq_clr_i = 1'b0;
    #1;
    check("R8 irq cleared", key_irq_o, 0);
    fn_rd_i = 1'b1;
    #1;
    check("R8 code unchanged", host_rd_data_o, 10);
    cyc(1);
    fn_rd_i = 1'b0;
    release_all();
  endtask

  initial begin
    @(negedge clk);
    fork
      begin
        t_reset();
        t_stepper();
        t_single_key();
        t_short_press();
        t_multi();
        t_ghost();
        t_hold_one();
        t_backpressure();
        t_clear();
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule